// File: doc/BRIEF.md
# SMBus Indexed Block-Access Configuration Slave

This block is a two-wire bus slave that holds a bank of eight 8-bit configuration registers for a clock generator. A host reaches the bank only through indexed block transfers. A transfer always names a starting register index. A write also carries a byte count that limits how many of the following data bytes are stored. A read is set up by a write-addressed phase that carries the index, followed by a repeated start on the read address. The slave then returns a count byte and streams register contents until the host answers with a not-acknowledge.

The bus lines enter as plain inputs. The slave pulls SDA low only by raising `sda_oe`, and the pad is open-drain. Both lines are oversampled on the system clock, synchronised and glitch filtered. Start and stop are recognised as SDA edges while SCL is high. The register bank is presented in parallel on `cfg_out`, with register i at bits 8i+7 down to 8i. Register 0 is a live mirror of four status pins. Register 7 carries a fixed identity byte.

Top module: `smb_cfg_slave`

## Requirements
- R1: After reset the registers hold, by index 0..7: {0000, status pins}, 7Fh, 00h, FFh, 47h, 9Fh, 03h, {REV_ID, 0001}. `sda_oe` is low.
- R2: Address byte D2h (write) or D3h (read) is acknowledged. Any other address byte is not acknowledged, and the slave stays silent and changes nothing until the next start.
- R3: A write transfer (start, D2h, index N, count X, data) acknowledges every byte and stores the data bytes into registers N, N+1, ... in order. The index advances by one per data byte.
- R4: Data bytes beyond the first X in a write transfer are acknowledged but not stored.
- R5: An index of 8 or more is acknowledged. Writes there change nothing, and reads there return 00h. The index stops advancing at FFh.
- R6: A read transfer (start, D2h, N, repeated start, D3h) first returns a count byte equal to 8−N (00h when N ≥ 8). It then returns the data from N upward while the host acknowledges. A host not-acknowledge ends the transfer, and the slave releases SDA.
- R7: Register 0 reads {0000, pin_state}, where pin_state[3] is PCI stop, [2] is CPU stop, [1] is FS_B and [0] is FS_A. It follows the pins and ignores writes.
- R8: Register 7 reads {REV_ID, 0001} and ignores writes.
- R9: Reserved bits (register 5 bit 6, register 6 bits 6 and 3) read 0 and ignore writes. All other bits of registers 1 to 6 are writable.
- R10: `sda_oe` changes only after an SCL fall, a start or a stop, and it is low in the cycle after any stop.
- R11: An SDA pulse shorter than FILT_LEN system clocks while SCL is high is neither a start nor a stop, and the transfer in progress continues unharmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| pin_state | input | 4 | Live status pins mirrored into register 0 |
| cfg_out | output | 64 | All eight registers, register i in bits 8i+7:8i |

## Verification
The assertions assume that the bus is well-formed after filtering. SCL and SDA never change in the same filtered cycle, and every bus phase lasts far longer than the synchroniser and filter delay. The stimulus meets this by moving SDA only while SCL has been low for a quarter bit time, and by spacing each line change twelve system clocks apart. The only deliberate breach is the single-clock SDA pulse for the glitch case. The host also never drives SDA during a phase in which the slave transmits, so a stop is only issued after the slave has released the line.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);
  localparam int PIN_W = 4;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK} xfer_st_t;
  typedef enum logic [1:0] {K_ADDR, K_INDEX, K_COUNT, K_DATA} byte_kind_t;

  // Value loaded into a register on reset
  function automatic logic [7:0] reg_reset(input int i);
    case (i)
      1:       return 8'h7F;
      3:       return 8'hFF;
      4:       return 8'h47;
      5:       return 8'h9F;
      6:       return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  // Bits a host write may change
  function automatic logic [7:0] reg_wmask(input int i);
    case (i)
      1, 2, 3, 4: return 8'hFF;
      5:          return 8'hBF;
      6:          return 8'hB7;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic line_raw,
  output logic line_q
);
  localparam int CW = $clog2(FILT_LEN) + 1;

  logic [1:0]    sync;
  logic [CW-1:0] run;

  // Two-flop synchroniser, then accept a new level only after FILT_LEN equal samples
  always_ff @(posedge clk) begin
    if (rst) begin
      sync   <= 2'b11;
      run    <= '0;
      line_q <= 1'b1;
    end else begin
      sync <= {sync[0], line_raw};
      if (sync[1] != line_q) begin
        if (run == CW'(FILT_LEN - 1)) begin
          line_q <= sync[1];
          run    <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        run <= '0;
      end
    end
  end
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p,
  output logic sda_q
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw, filt, prev;

  assign raw = {sda_in, scl_in};

  generate
    for (genvar g = 0; g < NLINE; g++) begin : g_line
      smb_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .line_raw (raw[g]),
        .line_q   (filt[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= '1;
    else     prev <= filt;
  end

  assign scl_rise = filt[0] & ~prev[0];
  assign scl_fall = ~filt[0] & prev[0];
  assign start_p  = filt[0] & prev[0] & prev[1] & ~filt[1];
  assign stop_p   = filt[0] & prev[0] & ~prev[1] & filt[1];
  assign sda_q    = filt[1];
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR = 8'hD2,
  parameter logic [7:0] RD_ADDR = 8'hD3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_p,
  input  logic       stop_p,
  input  logic       sda_q,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_idx,
  output logic       wr_en,
  output logic [7:0] wr_idx,
  output logic [7:0] wr_data,
  output logic       sda_oe
);
  xfer_st_t   st;
  byte_kind_t kind;
  logic [7:0] shreg, txsh, idx, wleft, cnt_byte;
  logic [3:0] bits;
  logic       rd_mode, host_ack;

  assign rd_idx   = idx;
  assign cnt_byte = (idx < 8'(NREG)) ? (8'(NREG) - idx) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      kind     <= K_ADDR;
      shreg    <= '0;
      txsh     <= '0;
      idx      <= '0;
      wleft    <= '0;
      bits     <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_p) begin
        st     <= ST_RX;
        kind   <= K_ADDR;
        bits   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_q};
              bits  <= bits + 4'd1;
            end else if (scl_fall && bits == 4'd8) begin
              bits <= '0;
              case (kind)
                K_ADDR: begin
                  if (shreg == WR_ADDR || shreg == RD_ADDR) begin
                    rd_mode <= (shreg == RD_ADDR);
                    kind    <= K_INDEX;
                    sda_oe  <= 1'b1;
                    st      <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                K_INDEX: begin
                  idx    <= shreg;
                  kind   <= K_COUNT;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                K_COUNT: begin
                  wleft  <= shreg;
                  kind   <= K_DATA;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
                default: begin
                  if (wleft != 8'h00) begin
                    wr_en   <= 1'b1;
                    wr_idx  <= idx;
                    wr_data <= shreg;
                    wleft   <= wleft - 8'd1;
                  end
                  if (idx != 8'hFF) idx <= idx + 8'd1;
                  sda_oe <= 1'b1;
                  st     <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              if (rd_mode) begin
                txsh   <= cnt_byte;
                sda_oe <= ~cnt_byte[7];
                bits   <= '0;
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bits == 4'd7) begin
                sda_oe <= 1'b0;
                bits   <= '0;
                st     <= ST_TX_ACK;
              end else begin
                bits   <= bits + 4'd1;
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_q;
            end else if (scl_fall) begin
              if (host_ack) begin
                txsh   <= rd_data;
                sda_oe <= ~rd_data[7];
                if (idx != 8'hFF) idx <= idx + 8'd1;
                st     <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  release_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    stop_p |=> !sda_oe);

  // R10
  drive_edge_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_p || stop_p));

  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
  import smb_cfg_pkg::*;
#(
  parameter logic [3:0] REV_ID = 4'h7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [7:0]           wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           rd_idx,
  output logic [7:0]           rd_data,
  input  logic [PIN_W-1:0]     pin_state,
  output logic [NREG*8-1:0]    cfg_out
);
  logic [NREG-1:0][7:0] regq, view;
  logic [PIN_W-1:0]     pins_q;

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [7:0] RST_V = reg_reset(i);
      localparam logic [7:0] MASK  = reg_wmask(i);
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                q <= RST_V;
        else if (wr_en && wr_idx == 8'(i))      q <= (q & ~MASK) | (wr_data & MASK);
      end
      assign regq[i] = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pins_q <= '0;
    else     pins_q <= pin_state;
  end

  always_comb begin
    view          = regq;
    view[0]       = {{(8-PIN_W){1'b0}}, pins_q};
    view[NREG-1]  = {REV_ID, 4'b0001};
  end

  assign rd_data = (rd_idx < 8'(NREG)) ? view[rd_idx[IDX_W-1:0]] : 8'h00;
  assign cfg_out = view;

  // R5
  oob_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx >= 8'(NREG)) |=> $stable(regq));

  // R3
  no_stray_write_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regq));
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter logic [7:0] WR_ADDR  = 8'hD2,
  parameter logic [7:0] RD_ADDR  = 8'hD3,
  parameter int         FILT_LEN = 3,
  parameter logic [3:0] REV_ID   = 4'h7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [3:0]        pin_state,
  output logic [63:0]       cfg_out
);
  logic       scl_rise, scl_fall, start_p, stop_p, sda_q;
  logic       wr_en;
  logic [7:0] wr_idx, wr_data, rd_idx, rd_data;

  smb_bus_cond #(.FILT_LEN(FILT_LEN)) u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .sda_q    (sda_q)
  );

  smb_xfer_fsm #(.WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .sda_q    (sda_q),
    .rd_data  (rd_data),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  smb_reg_bank #(.REV_ID(REV_ID)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .pin_state (pin_state),
    .cfg_out   (cfg_out)
  );
endmodule

// File: tb/smb_cfg_slave_bench.sv
module smb_cfg_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_drv = 1'b1;
  logic       host_low = 1'b0;
  logic [3:0] pin_state = 4'b1010;
  logic       sda_oe;
  logic [63:0] cfg_out;
  wire        sda_line = ~(host_low | sda_oe);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got;
  event       byte_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_cfg_slave u_smb_cfg_slave (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_drv),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .pin_state (pin_state),
    .cfg_out   (cfg_out)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input logic [7:0] r0, r1, r2, r3, r4, r5, r6, r7);
    return {r7, r6, r5, r4, r3, r2, r1, r0};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    host_low = 1'b0; tick(Q);
    scl_drv  = 1'b1; tick(Q);
    host_low = 1'b1; tick(Q);
    scl_drv  = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    host_low = 1'b1; tick(Q);
    scl_drv  = 1'b1; tick(Q);
    host_low = 1'b0; tick(Q);
    check("R10 released after stop", {63'd0, sda_oe}, 64'd0);
  endtask

  task automatic put_bit(input bit b, input bit glitch);
    host_low = ~b; tick(Q);
    scl_drv  = 1'b1;
    if (glitch) begin
      tick(Q);
      host_low = 1'b0; tick(1);
      host_low = 1'b1; tick(Q - 1);
    end else begin
      tick(2 * Q);
    end
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output bit b);
    host_low = 1'b0; tick(Q);
    scl_drv  = 1'b1; tick(Q);
    b = sda_line;    tick(Q);
    scl_drv  = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output bit acked);
    bit b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch && (i == 7));
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input bit last);
    bit b;
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(last, 1'b0);
    got = v;
    -> byte_ev;
  endtask

  // Write: start, D2h, index, count, n data bytes, stop; every byte must be acknowledged
  task automatic wr_blk(input logic [7:0] idx, input logic [7:0] cnt,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                        input int n, input bit glitch, input string req);
    bit a;
    logic [7:0] d[3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    bus_start();
    send_byte(8'hD2, 1'b0, a); check("R2 write address ack", {63'd0, a}, 64'd1);
    send_byte(idx, 1'b0, a);   check({req, " index ack"}, {63'd0, a}, 64'd1);
    send_byte(cnt, 1'b0, a);   check({req, " count ack"}, {63'd0, a}, 64'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], glitch && (i == 0), a);
      check({req, " data ack"}, {63'd0, a}, 64'd1);
    end
    bus_stop();
  endtask

  // Read: start, D2h, index, restart, D3h, then count byte and nbytes data; expectations queued by caller
  task automatic rd_blk(input logic [7:0] idx, input int nbytes);
    bit a;
    bus_start();
    send_byte(8'hD2, 1'b0, a); check("R6 setup address ack", {63'd0, a}, 64'd1);
    send_byte(idx, 1'b0, a);   check("R6 index ack", {63'd0, a}, 64'd1);
    bus_start();
    send_byte(8'hD3, 1'b0, a); check("R2 read address ack", {63'd0, a}, 64'd1);
    recv_byte(nbytes == 0);
    for (int i = 0; i < nbytes; i++) recv_byte(i == nbytes - 1);
    bus_stop();
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // Scoreboard monitor: pops one expectation per byte the slave delivers
  initial begin
    forever begin
      @(byte_ev);
      if (exp_q.size() == 0) begin
        check("R6 unexpected byte", {56'd0, got}, 64'hxx);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {56'd0, got}, {56'd0, e});
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    bit a;
    tick(5);
    rst = 1'b0;
    tick(3);
    // R1 reset values, register 0 already mirrors pins 1010
    check("R1 reset register values", cfg_out, pack(8'h0A, 8'h7F, 8'h00, 8'hFF, 8'h47, 8'h9F, 8'h03, 8'h71));
    check("R1 sda released at reset", {63'd0, sda_oe}, 64'd0);

    // R3 block write of three registers
    wr_blk(8'h01, 8'h03, 8'h11, 8'h22, 8'h33, 3, 1'b0, "R3");
    check("R3 registers 1..3 written", cfg_out, pack(8'h0A, 8'h11, 8'h22, 8'h33, 8'h47, 8'h9F, 8'h03, 8'h71));

    // R4 second data byte exceeds count 1
    wr_blk(8'h04, 8'h01, 8'hAA, 8'hBB, 8'h00, 2, 1'b0, "R4");
    check("R4 byte beyond count not stored", cfg_out, pack(8'h0A, 8'h11, 8'h22, 8'h33, 8'hAA, 8'h9F, 8'h03, 8'h71));

    // R7 write into register 0 ignored, index then advances to register 1
    wr_blk(8'h00, 8'h02, 8'hFF, 8'hFF, 8'h00, 2, 1'b0, "R7");
    check("R7 register 0 ignores writes", cfg_out, pack(8'h0A, 8'hFF, 8'h22, 8'h33, 8'hAA, 8'h9F, 8'h03, 8'h71));

    // R8 R9 reserved and identity bits
    wr_blk(8'h05, 8'h03, 8'hFF, 8'hFF, 8'hFF, 3, 1'b0, "R9");
    check("R9 reserved bits stay 0 and R8 id kept", cfg_out, pack(8'h0A, 8'hFF, 8'h22, 8'h33, 8'hAA, 8'hBF, 8'hB7, 8'h71));

    // R5 write beyond the bank
    wr_blk(8'h08, 8'h02, 8'h55, 8'h55, 8'h00, 2, 1'b0, "R5");
    check("R5 out-of-range write inert", cfg_out, pack(8'h0A, 8'hFF, 8'h22, 8'h33, 8'hAA, 8'hBF, 8'hB7, 8'h71));

    // R2 foreign address: no acknowledge, following bytes ignored
    bus_start();
    send_byte(8'hA4, 1'b0, a); check("R2 foreign address not acked", {63'd0, a}, 64'd0);
    send_byte(8'h01, 1'b0, a); check("R2 silent after mismatch", {63'd0, a}, 64'd0);
    send_byte(8'h01, 1'b0, a); check("R2 silent after mismatch", {63'd0, a}, 64'd0);
    send_byte(8'h00, 1'b0, a); check("R2 silent after mismatch", {63'd0, a}, 64'd0);
    bus_stop();
    check("R2 registers unchanged", cfg_out, pack(8'h0A, 8'hFF, 8'h22, 8'h33, 8'hAA, 8'hBF, 8'hB7, 8'h71));

    // R11 one-clock SDA pulse while SCL high during the first data bit
    wr_blk(8'h02, 8'h01, 8'h5A, 8'h00, 8'h00, 1, 1'b1, "R11");
    check("R11 glitch ignored, write completes", cfg_out, pack(8'h0A, 8'hFF, 8'h5A, 8'h33, 8'hAA, 8'hBF, 8'hB7, 8'h71));

    // R6 full read from index 0
    expect_byte(8'h08, "R6 count byte from index 0");
    expect_byte(8'h0A, "R7 register 0 mirrors pins");
    expect_byte(8'hFF, "R6 register 1");
    expect_byte(8'h5A, "R6 register 2");
    expect_byte(8'h33, "R6 register 3");
    expect_byte(8'hAA, "R6 register 4");
    expect_byte(8'hBF, "R9 register 5");
    expect_byte(8'hB7, "R9 register 6");
    expect_byte(8'h71, "R8 identity register");
    rd_blk(8'h00, 8);

    // R5 read running past the end
    expect_byte(8'h02, "R6 count byte from index 6");
    expect_byte(8'hB7, "R6 register 6");
    expect_byte(8'h71, "R8 identity register");
    expect_byte(8'h00, "R5 read past end is zero");
    rd_blk(8'h06, 3);

    // R5 read starting beyond the bank
    expect_byte(8'h00, "R5 count byte beyond bank");
    expect_byte(8'h00, "R5 data beyond bank");
    rd_blk(8'h09, 1);

    // R7 pin change follows live
    pin_state = 4'b0101;
    tick(4);
    expect_byte(8'h08, "R6 count byte from index 0");
    expect_byte(8'h05, "R7 register 0 follows pins");
    rd_blk(8'h00, 1);

    tick(20);
    check("R6 all expected bytes delivered", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule